// File: doc/BRIEF.md
# Direct-Store Bus Requester

This block sits between a processor core and a split address/data system bus. It carries out loads and stores that target an I/O-style (direct-store) segment. The core presents one operation at a time. The requester latches the operation and builds an 8-bit extended transfer code that holds both the command and the byte count. It then wins the address bus and presents the address tenure. If the target pushes back with an address retry, it waits and presents the same tenure again. After that it wins the data bus, which has its own arbitration, and moves a single beat of at most four bytes on the upper half of the data lines. Even byte parity travels alongside the beat.

Once the beat is done, the requester watches snooped address-only tenures for the reply that the addressed bus unit controller sends back. The reply's error bit, a read-parity mismatch or an expired reply timer turn the completion into an error. A stall line toward instruction issue stays high for the whole life of the operation, and no new operation is accepted until the completion pulse has been given.

The controller is a single state machine with these states: IDLE, ADDR_REQ, ADDR_TEN, RETRY_WAIT, DATA_REQ, DATA_TEN, REPLY_WAIT and FINISH. Its transitions are:
- accept: IDLE to ADDR_REQ when `op_valid` is high.
- addr_grant: ADDR_REQ to ADDR_TEN on `abus_grant`.
- addr_done: ADDR_TEN to DATA_REQ on `a_ack` without `a_retry`.
- retried: ADDR_TEN to RETRY_WAIT on `a_ack` with `a_retry`.
- gap_over: RETRY_WAIT to ADDR_REQ after `RETRY_GAP` cycles.
- data_grant: DATA_REQ to DATA_TEN on `dbus_grant`.
- beat_done: DATA_TEN to REPLY_WAIT on `d_ta`.
- replied or expired: REPLY_WAIT to FINISH.
- release: FINISH to IDLE.

Top module: `dsr_requester`

## Requirements
- R1: `a_xcode` is laid out as follows. Bits [7:4] hold the command type: 4'h1 for a store and 4'h5 for a load. Bit 3 is the burst flag and is always 0. Bits [2:0] hold the byte count. An `op_size` of 1 to 4 is sent unchanged, and 0 or any value above 4 is sent as 4.
- R2: `abus_req` is high from the cycle after acceptance until the grant. `a_start` is then high until `a_ack`, with `a_addr` and `a_xcode` held stable for that whole time.
- R3: `dbus_req` rises only after an address tenure that ends without retry, and it is never high at the same time as `abus_req`.
- R4: For a store, `d_drive` is high during the data tenure. During that tenure `d_hi_out` carries the store data and `d_par_out[k]` gives even parity over `d_hi_out[8k+7:8k]`. For a load, `d_drive` stays low.
- R5: For a load, `done_rdata` equals `d_hi_in` as sampled with `d_ta`. `d_lo_in` and `d_lo_par_in` have no effect. If `d_par_in` does not give even parity per byte lane, `done_err` is set.
- R6: When `a_ack` arrives together with `a_retry`, `abus_req` stays low for exactly `RETRY_GAP` cycles. The same address and code are then requested and presented again.
- R7: Completion follows only a snooped tenure (`snp_valid`) whose `snp_xcode[7:4]` is 4'hB, and `snp_xcode[0]` of that tenure is its error flag. Snooped tenures of any other type are ignored.
- R8: If no reply arrives within `TIMEOUT_CYC` cycles of entering REPLY_WAIT, completion is given with `done_err` set. A reply in the last of those cycles takes precedence over the timeout.
- R9: `done_valid` is a one-cycle pulse that comes in the cycle after the reply or timeout. `done_rdata` is 0 for a store.
- R10: `issue_stall` is high and `op_ready` is low from the cycle after acceptance through the completion cycle. Any `op_valid` presented in that time is ignored.
- R11: After reset, `op_ready` is high and every bus request, strobe and completion output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Core presents an operation |
| op_write | input | 1 | 1 = store, 0 = load |
| op_addr | input | AW | Operation address |
| op_size | input | 3 | Byte count |
| op_wdata | input | 8*LANES | Store data |
| op_ready | output | 1 | Requester idle, operation accepted this cycle |
| done_valid | output | 1 | Completion pulse |
| done_err | output | 1 | Completion carries an error |
| done_rdata | output | 8*LANES | Load data at completion |
| issue_stall | output | 1 | Stall toward instruction issue |
| abus_req | output | 1 | Address bus request |
| abus_grant | input | 1 | Address bus grant |
| a_start | output | 1 | Address tenure active |
| a_addr | output | AW | Address during tenure |
| a_xcode | output | 8 | Extended transfer code |
| a_ack | input | 1 | Address tenure acknowledge |
| a_retry | input | 1 | Retry, sampled with a_ack |
| dbus_req | output | 1 | Data bus request |
| dbus_grant | input | 1 | Data bus grant |
| d_drive | output | 1 | Requester drives data lines |
| d_hi_out | output | 8*LANES | Upper data lines out |
| d_par_out | output | LANES | Upper data parity out |
| d_ta | input | 1 | Data beat acknowledge |
| d_hi_in | input | 8*LANES | Upper data lines in |
| d_par_in | input | LANES | Upper data parity in |
| d_lo_in | input | 8*LANES | Lower data lines in (ignored) |
| d_lo_par_in | input | LANES | Lower data parity in (ignored) |
| snp_valid | input | 1 | Snooped address-only tenure |
| snp_xcode | input | 8 | Snooped transfer code |

## Verification
The reply match and the timeout expiry can both fire in the final cycle of REPLY_WAIT. The bench provokes this by holding back a clean reply for exactly `TIMEOUT_CYC`-1 cycles after the data beat. If the reply wins, the completion arrives with `done_err` clear, and an error there shows the timer won instead. A second overlap is a non-reply snooped tenure arriving while the reply is awaited. The bench drives one and confirms that no completion pulse follows in the next cycle.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR_REQ,
        ST_ADDR_TEN,
        ST_RETRY_WAIT,
        ST_DATA_REQ,
        ST_DATA_TEN,
        ST_REPLY_WAIT,
        ST_FINISH
    } dsr_state_e;

    localparam logic [3:0] XT_STORE = 4'h1;
    localparam logic [3:0] XT_LOAD  = 4'h5;
    localparam logic [3:0] XT_REPLY = 4'hB;

    typedef struct packed {
        logic [3:0] ttype;
        logic       burst;
        logic [2:0] size;
    } xcode_t;

endpackage

// File: rtl/dsr_xcode.sv
module dsr_xcode
    import dsr_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic       is_write,
    input  logic [2:0] req_size,
    input  logic [7:0] snp_code,
    output logic [7:0] xcode,
    output logic       snp_is_reply,
    output logic       snp_err
);
    localparam logic [2:0] FULL = 3'(LANES);

    xcode_t tx;
    xcode_t rx;

    // Outgoing code: command, no burst, clamped byte count
    always_comb begin
        tx.ttype = is_write ? XT_STORE : XT_LOAD;
        tx.burst = 1'b0;
        if (req_size == 3'd0 || req_size > FULL) begin
            tx.size = FULL;
        end else begin
            tx.size = req_size;
        end
    end

    assign xcode = tx;

    // Incoming snooped code: reply type and its error flag
    assign rx           = snp_code;
    assign snp_is_reply = (rx.ttype == XT_REPLY);
    assign snp_err      = rx.size[0];

    logic unused_rx;
    assign unused_rx = ^{rx.burst, rx.size[2:1]};

endmodule

// File: rtl/dsr_parity.sv
module dsr_parity #(
    parameter int LANES = 4
) (
    input  logic [8*LANES-1:0] data,
    output logic [LANES-1:0]   par
);
    // Even parity per byte lane: lane bits plus parity bit hold an even count of ones
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign par[k] = ^data[8*k +: 8];
    end

endmodule

// File: rtl/dsr_timer.sv
module dsr_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    // Counts cycles spent in the current state, saturating at all ones
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (cnt != {W{1'b1}}) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/dsr_ctrl.sv
module dsr_ctrl
    import dsr_pkg::*;
#(
    parameter int TIMEOUT_CYC = 64,
    parameter int RETRY_GAP   = 4,
    parameter int TW          = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic          abus_grant,
    input  logic          a_ack,
    input  logic          a_retry,
    input  logic          dbus_grant,
    input  logic          d_ta,
    input  logic          snp_hit,
    input  logic [TW-1:0] tmr_cnt,
    output logic          tmr_clr,
    output logic          op_accept,
    output logic          idle,
    output logic          abus_req,
    output logic          a_start,
    output logic          dbus_req,
    output logic          d_phase,
    output logic          take_data,
    output logic          reply_hit,
    output logic          timeout_hit,
    output logic          done
);
    localparam logic [TW-1:0] GAP_LAST = TW'(RETRY_GAP - 1);
    localparam logic [TW-1:0] TO_LAST  = TW'(TIMEOUT_CYC - 1);

    dsr_state_e state;
    dsr_state_e nxt;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:       if (op_valid)   nxt = ST_ADDR_REQ;
            ST_ADDR_REQ:   if (abus_grant) nxt = ST_ADDR_TEN;
            ST_ADDR_TEN: begin
                if (a_ack) begin
                    nxt = a_retry ? ST_RETRY_WAIT : ST_DATA_REQ;
                end
            end
            ST_RETRY_WAIT: if (tmr_cnt == GAP_LAST) nxt = ST_ADDR_REQ;
            ST_DATA_REQ:   if (dbus_grant) nxt = ST_DATA_TEN;
            ST_DATA_TEN:   if (d_ta)       nxt = ST_REPLY_WAIT;
            ST_REPLY_WAIT: begin
                if (snp_hit || tmr_cnt == TO_LAST) begin
                    nxt = ST_FINISH;
                end
            end
            ST_FINISH:     nxt = ST_IDLE;
            default:       nxt = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        idle        = 1'b0;
        op_accept   = 1'b0;
        abus_req    = 1'b0;
        a_start     = 1'b0;
        dbus_req    = 1'b0;
        d_phase     = 1'b0;
        take_data   = 1'b0;
        reply_hit   = 1'b0;
        timeout_hit = 1'b0;
        done        = 1'b0;
        unique case (state)
            ST_IDLE: begin
                idle      = 1'b1;
                op_accept = op_valid;
            end
            ST_ADDR_REQ:   abus_req = 1'b1;
            ST_ADDR_TEN:   a_start  = 1'b1;
            ST_RETRY_WAIT: ;
            ST_DATA_REQ:   dbus_req = 1'b1;
            ST_DATA_TEN: begin
                d_phase   = 1'b1;
                take_data = d_ta;
            end
            ST_REPLY_WAIT: begin
                reply_hit   = snp_hit;
                timeout_hit = !snp_hit && (tmr_cnt == TO_LAST);
            end
            ST_FINISH:     done = 1'b1;
            default: ;
        endcase
    end

    assign tmr_clr = (nxt != state);

endmodule

// File: rtl/dsr_requester.sv
module dsr_requester #(
    parameter int AW          = 32,
    parameter int LANES       = 4,
    parameter int TIMEOUT_CYC = 64,
    parameter int RETRY_GAP   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_valid,
    input  logic                 op_write,
    input  logic [AW-1:0]        op_addr,
    input  logic [2:0]           op_size,
    input  logic [8*LANES-1:0]   op_wdata,
    output logic                 op_ready,
    output logic                 done_valid,
    output logic                 done_err,
    output logic [8*LANES-1:0]   done_rdata,
    output logic                 issue_stall,
    output logic                 abus_req,
    input  logic                 abus_grant,
    output logic                 a_start,
    output logic [AW-1:0]        a_addr,
    output logic [7:0]           a_xcode,
    input  logic                 a_ack,
    input  logic                 a_retry,
    output logic                 dbus_req,
    input  logic                 dbus_grant,
    output logic                 d_drive,
    output logic [8*LANES-1:0]   d_hi_out,
    output logic [LANES-1:0]     d_par_out,
    input  logic                 d_ta,
    input  logic [8*LANES-1:0]   d_hi_in,
    input  logic [LANES-1:0]     d_par_in,
    input  logic [8*LANES-1:0]   d_lo_in,
    input  logic [LANES-1:0]     d_lo_par_in,
    input  logic                 snp_valid,
    input  logic [7:0]           snp_xcode
);
    localparam int DW   = 8 * LANES;
    localparam int CMAX = (TIMEOUT_CYC > RETRY_GAP) ? TIMEOUT_CYC : RETRY_GAP;
    localparam int TW   = $clog2(CMAX + 1);

    // Latched operation and result flags
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata_q;
    logic [2:0]    size_q;
    logic          wr_q;
    logic          par_bad_q;
    logic          rep_err_q;
    logic          to_err_q;

    logic          op_accept, idle, d_phase, take_data;
    logic          reply_hit, timeout_hit, done;
    logic          tmr_clr, snp_is_reply, snp_err, snp_hit;
    logic [TW-1:0] tmr_cnt;
    logic [7:0]    xcode;
    logic [LANES-1:0] rd_par;

    assign snp_hit = snp_valid && snp_is_reply;

    dsr_xcode #(.LANES(LANES)) u_xcode (
        .is_write     (wr_q),
        .req_size     (size_q),
        .snp_code     (snp_xcode),
        .xcode        (xcode),
        .snp_is_reply (snp_is_reply),
        .snp_err      (snp_err)
    );

    dsr_timer #(.W(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .cnt   (tmr_cnt)
    );

    dsr_ctrl #(
        .TIMEOUT_CYC (TIMEOUT_CYC),
        .RETRY_GAP   (RETRY_GAP),
        .TW          (TW)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_valid    (op_valid),
        .abus_grant  (abus_grant),
        .a_ack       (a_ack),
        .a_retry     (a_retry),
        .dbus_grant  (dbus_grant),
        .d_ta        (d_ta),
        .snp_hit     (snp_hit),
        .tmr_cnt     (tmr_cnt),
        .tmr_clr     (tmr_clr),
        .op_accept   (op_accept),
        .idle        (idle),
        .abus_req    (abus_req),
        .a_start     (a_start),
        .dbus_req    (dbus_req),
        .d_phase     (d_phase),
        .take_data   (take_data),
        .reply_hit   (reply_hit),
        .timeout_hit (timeout_hit),
        .done        (done)
    );

    dsr_parity #(.LANES(LANES)) u_par_out (
        .data (d_hi_out),
        .par  (d_par_out)
    );

    dsr_parity #(.LANES(LANES)) u_par_in (
        .data (d_hi_in),
        .par  (rd_par)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            wdata_q   <= '0;
            rdata_q   <= '0;
            size_q    <= '0;
            wr_q      <= 1'b0;
            par_bad_q <= 1'b0;
            rep_err_q <= 1'b0;
            to_err_q  <= 1'b0;
        end else begin
            if (op_accept) begin
                addr_q    <= op_addr;
                wdata_q   <= op_wdata;
                size_q    <= op_size;
                wr_q      <= op_write;
                rdata_q   <= '0;
                par_bad_q <= 1'b0;
                rep_err_q <= 1'b0;
                to_err_q  <= 1'b0;
            end
            if (take_data && !wr_q) begin
                rdata_q   <= d_hi_in;
                par_bad_q <= (rd_par != d_par_in);
            end
            if (reply_hit) begin
                rep_err_q <= snp_err;
            end
            if (timeout_hit) begin
                to_err_q <= 1'b1;
            end
        end
    end

    assign op_ready    = idle;
    assign issue_stall = !idle;
    assign a_addr      = a_start ? addr_q : '0;
    assign a_xcode     = a_start ? xcode  : 8'h00;
    assign d_drive     = d_phase && wr_q;
    assign d_hi_out    = d_drive ? wdata_q : '0;
    assign done_valid  = done;
    assign done_err    = done && (par_bad_q || rep_err_q || to_err_q);
    assign done_rdata  = done ? rdata_q : '0;

    logic unused_lower;
    assign unused_lower = ^{d_lo_in, d_lo_par_in};

endmodule

// File: rtl/dsr_requester_chk.sv
module dsr_requester_chk #(
    parameter int AW    = 32,
    parameter int LANES = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               op_ready,
    input logic               issue_stall,
    input logic               abus_req,
    input logic               dbus_req,
    input logic               a_start,
    input logic               a_ack,
    input logic               a_retry,
    input logic [AW-1:0]      a_addr,
    input logic [7:0]         a_xcode,
    input logic               d_drive,
    input logic [8*LANES-1:0] d_hi_out,
    input logic [LANES-1:0]   d_par_out,
    input logic               done_valid
);

    p_code_shape_r1: assert property (@(posedge clk) disable iff (!rst_n)
        a_start |-> (a_xcode[3] == 1'b0 && a_xcode[2:0] != 3'd0 && a_xcode[2:0] <= 3'd4));

    p_tenure_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (a_start && !a_ack) |=> (a_start && $stable(a_addr) && $stable(a_xcode)));

    p_split_arb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(abus_req && dbus_req) && !(a_start && d_drive));

    p_even_par_r4: assert property (@(posedge clk) disable iff (!rst_n)
        d_drive |-> ((^{d_hi_out[7:0],   d_par_out[0]}) == 1'b0 &&
                     (^{d_hi_out[15:8],  d_par_out[1]}) == 1'b0 &&
                     (^{d_hi_out[23:16], d_par_out[2]}) == 1'b0 &&
                     (^{d_hi_out[31:24], d_par_out[3]}) == 1'b0));

    p_retry_backoff_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (a_start && a_ack && a_retry) |=> (!abus_req && !a_start && !dbus_req));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> (!done_valid && op_ready));

    p_stall_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (a_start || dbus_req || done_valid) |-> (issue_stall && !op_ready));

endmodule

bind dsr_requester dsr_requester_chk #(.AW(AW), .LANES(LANES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_ready    (op_ready),
    .issue_stall (issue_stall),
    .abus_req    (abus_req),
    .dbus_req    (dbus_req),
    .a_start     (a_start),
    .a_ack       (a_ack),
    .a_retry     (a_retry),
    .a_addr      (a_addr),
    .a_xcode     (a_xcode),
    .d_drive     (d_drive),
    .d_hi_out    (d_hi_out),
    .d_par_out   (d_par_out),
    .done_valid  (done_valid)
);

// File: tb/dsr_requester_bench.sv
module dsr_requester_bench;

    localparam int CLK_PERIOD  = 10;
    localparam int TIMEOUT_CYC = 16;
    localparam int RETRY_GAP   = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0, op_write = 1'b0;
    logic [31:0] op_addr = '0, op_wdata = '0;
    logic [2:0]  op_size = '0;
    logic        op_ready, done_valid, done_err, issue_stall;
    logic [31:0] done_rdata;
    logic        abus_req, abus_grant = 1'b0, a_start, a_ack = 1'b0, a_retry = 1'b0;
    logic [31:0] a_addr;
    logic [7:0]  a_xcode;
    logic        dbus_req, dbus_grant = 1'b0, d_drive, d_ta = 1'b0;
    logic [31:0] d_hi_out, d_hi_in = '0, d_lo_in = '0;
    logic [3:0]  d_par_out, d_par_in = '0, d_lo_par_in = '0;
    logic        snp_valid = 1'b0;
    logic [7:0]  snp_xcode = '0;

    int n_total = 0;
    int n_bad   = 0;

    typedef struct {
        logic        err;
        logic [31:0] rdata;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dsr_requester #(
        .AW(32), .LANES(4), .TIMEOUT_CYC(TIMEOUT_CYC), .RETRY_GAP(RETRY_GAP)
    ) u_dsr_requester (
        .clk(clk), .rst_n(rst_n),
        .op_valid(op_valid), .op_write(op_write), .op_addr(op_addr),
        .op_size(op_size), .op_wdata(op_wdata), .op_ready(op_ready),
        .done_valid(done_valid), .done_err(done_err), .done_rdata(done_rdata),
        .issue_stall(issue_stall),
        .abus_req(abus_req), .abus_grant(abus_grant), .a_start(a_start),
        .a_addr(a_addr), .a_xcode(a_xcode), .a_ack(a_ack), .a_retry(a_retry),
        .dbus_req(dbus_req), .dbus_grant(dbus_grant), .d_drive(d_drive),
        .d_hi_out(d_hi_out), .d_par_out(d_par_out), .d_ta(d_ta),
        .d_hi_in(d_hi_in), .d_par_in(d_par_in), .d_lo_in(d_lo_in),
        .d_lo_par_in(d_lo_par_in), .snp_valid(snp_valid), .snp_xcode(snp_xcode)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_total++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] epar(input logic [31:0] d);
        logic [3:0] p;
        for (int k = 0; k < 4; k++) begin
            p[k] = 1'b0;
            for (int b = 0; b < 8; b++) p[k] = p[k] ^ d[8*k+b];
        end
        return p;
    endfunction

    // Monitor: pops the scoreboard on every completion pulse
    always @(negedge clk) begin
        if (rst_n && done_valid) begin
            if (sb.size() == 0) begin
                chk("R9", "unexpected completion", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk("R7", "done_err", {63'd0, done_err}, {63'd0, e.err});
                chk("R5", "done_rdata", {32'd0, done_rdata}, {32'd0, e.rdata});
            end
        end
    end

    // Driver and bus agent for one operation; rdelay < 0 means no reply
    task automatic run_op(input logic wr, input logic [31:0] addr, input logic [2:0] sz,
                          input logic [31:0] wd, input logic [31:0] rd, input logic par_ok,
                          input int retries, input logic foreign, input int rdelay,
                          input logic rerr, input logic hold);
        exp_t        e;
        logic [7:0]  xexp;
        int          n;
        xexp    = {wr ? 4'h1 : 4'h5, 1'b0, (sz == 3'd0 || sz > 3'd4) ? 3'd4 : sz};
        e.err   = (rdelay < 0) | rerr | (!wr & !par_ok);
        e.rdata = wr ? 32'd0 : rd;
        sb.push_back(e);

        @(negedge clk);
        op_valid = 1'b1; op_write = wr; op_addr = addr; op_size = sz; op_wdata = wd;
        @(negedge clk);
        chk("R10", "stall after accept", {63'd0, issue_stall}, 64'd1);
        chk("R10", "op_ready while busy", {63'd0, op_ready}, 64'd0);
        chk("R2", "abus_req after accept", {63'd0, abus_req}, 64'd1);
        if (hold) begin
            op_addr = addr ^ 32'hFFFF_0000;
            op_write = !wr;
            repeat (2) @(negedge clk);
        end
        op_valid = 1'b0;

        for (int r = 0; r <= retries; r++) begin
            n = 0;
            while (!abus_req && n < 100) begin
                @(negedge clk);
                n++;
            end
            if (r > 0) chk("R6", "retry gap length", 64'(n), 64'(RETRY_GAP));
            abus_grant = 1'b1;
            @(negedge clk);
            abus_grant = 1'b0;
            chk("R2", "a_start", {63'd0, a_start}, 64'd1);
            chk("R1", "a_xcode", {56'd0, a_xcode}, {56'd0, xexp});
            chk("R2", "a_addr", {32'd0, a_addr}, {32'd0, addr});
            chk("R3", "dbus_req during address tenure", {63'd0, dbus_req}, 64'd0);
            a_ack = 1'b1; a_retry = (r < retries);
            @(negedge clk);
            a_ack = 1'b0; a_retry = 1'b0;
            if (r < retries) chk("R6", "no request in gap", {63'd0, abus_req}, 64'd0);
        end

        chk("R3", "dbus_req after address", {63'd0, dbus_req}, 64'd1);
        chk("R3", "abus_req dropped", {63'd0, abus_req}, 64'd0);
        dbus_grant = 1'b1;
        @(negedge clk);
        dbus_grant = 1'b0;
        chk("R4", "d_drive", {63'd0, d_drive}, {63'd0, wr});
        if (wr) begin
            chk("R4", "d_hi_out", {32'd0, d_hi_out}, {32'd0, wd});
            chk("R4", "d_par_out", {60'd0, d_par_out}, {60'd0, epar(wd)});
        end
        d_ta = 1'b1; d_hi_in = rd;
        d_par_in = par_ok ? epar(rd) : (epar(rd) ^ 4'b0001);
        d_lo_in = 32'hDEAD_BEEF; d_lo_par_in = 4'hA;
        @(negedge clk);
        d_ta = 1'b0; d_hi_in = '0; d_par_in = '0; d_lo_in = '0; d_lo_par_in = '0;

        if (foreign) begin
            snp_valid = 1'b1; snp_xcode = 8'h51;
            @(negedge clk);
            snp_valid = 1'b0; snp_xcode = '0;
            chk("R7", "non-reply snoop ignored", {63'd0, done_valid}, 64'd0);
        end
        if (rdelay >= 0) begin
            repeat (rdelay) @(negedge clk);
            snp_valid = 1'b1; snp_xcode = {4'hB, 3'b000, rerr};
            @(negedge clk);
            snp_valid = 1'b0; snp_xcode = '0;
        end
        n = 0;
        while (!done_valid && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk("R9", "completion seen", {63'd0, done_valid}, 64'd1);
        if (rdelay >= 0) chk("R9", "completion right after reply", 64'(n), 64'd0);
        else             chk("R8", "timeout length", 64'(n), 64'(TIMEOUT_CYC));
        @(negedge clk);
        chk("R9", "done is one cycle", {63'd0, done_valid}, 64'd0);
        chk("R10", "ready again", {63'd0, op_ready}, 64'd1);
        chk("R10", "stall released", {63'd0, issue_stall}, 64'd0);
        chk("R10", "held op not accepted", {63'd0, abus_req}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "op_ready", {63'd0, op_ready}, 64'd1);
        chk("R11", "issue_stall", {63'd0, issue_stall}, 64'd0);
        chk("R11", "bus requests", {62'd0, abus_req, dbus_req}, 64'd0);
        chk("R11", "strobes", {61'd0, a_start, d_drive, done_valid}, 64'd0);

        // R4 store, full word, clean reply
        run_op(1'b1, 32'hF000_0010, 3'd4, 32'h8142_7F00, 32'h0, 1'b1, 0, 1'b0, 2, 1'b0, 1'b0);
        // R5 load, lower half noise, non-reply snoop first (R7)
        run_op(1'b0, 32'hF000_0024, 3'd2, 32'h0, 32'hA5C3_0F11, 1'b1, 0, 1'b1, 1, 1'b0, 1'b0);
        // R6 store retried twice
        run_op(1'b1, 32'hF000_0100, 3'd1, 32'h0000_0033, 32'h0, 1'b1, 2, 1'b0, 0, 1'b0, 1'b0);
        // R5 load with bad parity
        run_op(1'b0, 32'hF000_0200, 3'd3, 32'h0, 32'h1234_5678, 1'b0, 0, 1'b0, 0, 1'b0, 1'b0);
        // R7 store with error reply
        run_op(1'b1, 32'hF000_0300, 3'd2, 32'hFFFF_0001, 32'h0, 1'b1, 0, 1'b0, 3, 1'b1, 1'b0);
        // R8 load with no reply at all
        run_op(1'b0, 32'hF000_0400, 3'd4, 32'h0, 32'h0BAD_F00D, 1'b1, 0, 1'b0, -1, 1'b0, 1'b0);
        // R8 clean reply in the last waiting cycle wins over timeout
        run_op(1'b1, 32'hF000_0500, 3'd4, 32'h7777_1111, 32'h0, 1'b1, 0, 1'b0,
               TIMEOUT_CYC - 1, 1'b0, 1'b0);
        // R1 size 0 clamps to 4; R10 op held while busy
        run_op(1'b1, 32'hF000_0600, 3'd0, 32'h0102_0304, 32'h0, 1'b1, 0, 1'b0, 1, 1'b0, 1'b1);
        // R1 size 7 clamps to 4 on a load
        run_op(1'b0, 32'hF000_0700, 3'd7, 32'h0, 32'hFEDC_BA98, 1'b1, 1, 1'b0, 0, 1'b0, 1'b0);

        chk("R9", "scoreboard drained", 64'(sb.size()), 64'd0);
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_total++;
        n_bad++;
        $display("FAIL R9 watchdog expired: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

endmodule